// File: doc/BRIEF.md
# Transition-Mode PFC Gate Controller

This block drives the gate of the boost switch in a transition-mode power-factor pre-regulator. Its inputs are digital flags from analog comparators built elsewhere. The gate turns on when the boost inductor's demagnetisation-sense signal falls, which marks zero current in the inductor. It turns off when the current-sense comparator reports that the switch current has reached the sinusoidal reference.

A short blanking window after each turn-on hides the switching spike from the current-sense comparator. A maximum on-time puts an upper limit on every conduction interval. Inductor current is zero during start-up, so no demagnetisation edge ever arrives. For that case a restart timer fires a turn-on after a full period without one, and that timer is cleared at every turn-on.

Three conditions hold the gate off without latching: current above the saturation level, output over-voltage, and a deasserted enable. Switching picks up again on its own once the condition clears. All timings are in clock cycles and set by parameters. The defaults assume a 100 MHz clock: 200 ns blanking, about 66.7 µs restart period, and 25 µs maximum on-time.

Top module: `pfc_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_o` is 0.
- R2: In the cycle after `zcd_i` is sampled high and then low (a falling edge) while the gate is off and no stop condition holds, `gate_o` becomes 1.
- R3: With no falling edge on `zcd_i` and no stop condition, the gate turns on every `START_CYC` cycles, measured from one rise of `gate_o` to the next.
- R4: The restart timer is cleared at every turn-on, including one caused by `zcd_i`. The next automatic turn-on therefore comes exactly `START_CYC` cycles after the latest rise of `gate_o`.
- R5: `cs_trip_i` has no effect for the first `BLANK_CYC` cycles after a turn-on. When it is held high from the turn-on onward, `gate_o` stays high for exactly `BLANK_CYC`+1 cycles.
- R6: After blanking, `gate_o` falls in the cycle after `cs_trip_i` is sampled high.
- R7: With `cs_trip_i` low, `gate_o` falls after exactly `MAXON_CYC` high cycles.
- R8: While `cs_sat_i` is high, the gate is forced off in the next cycle, even during blanking, and cannot turn on. Once `cs_sat_i` returns low, switching resumes without a reset.
- R9: While `ovp_i` is high, the gate is held off. Once `ovp_i` returns low, switching resumes without a reset.
- R10: While `en_i` is low, the gate is held off. When `en_i` rises again, switching resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low holds the gate off |
| zcd_i | input | 1 | Demagnetisation-sense comparator level; a falling edge requests turn-on |
| cs_trip_i | input | 1 | Switch current at or above the reference |
| cs_sat_i | input | 1 | Switch current above the saturation level |
| ovp_i | input | 1 | Output over-voltage flag |
| gate_o | output | 1 | Gate command |

## Verification
Turn-on is tried from two sources: a falling edge on the demagnetisation input, and expiry of the restart timer with that input silent. Measuring the spacing between gate rises shows whether the timer is cleared by both kinds of turn-on. Turn-off is tried three ways: current trip held from turn-on, trip raised after blanking, and trip never raised. These three cases separate the blanking length, the trip latency and the maximum on-time. Each stop condition is raised in the middle of a conduction interval and held across a pending edge and a restart expiry. It is then released, to show that the stop acts at once, does not latch, and hands control back to the pending restart.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;
   // Counter width able to hold values 0..lim
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

   typedef enum logic [1:0] {
      STOP_NONE = 2'd0,
      STOP_SAT  = 2'd1,
      STOP_OVP  = 2'd2,
      STOP_DIS  = 2'd3
   } stop_cause_e;
endpackage

// File: rtl/pfc_zcd_edge.sv
module pfc_zcd_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zcd_i,
   output logic fall_o
);
   logic zcd_s;
   logic zcd_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign zcd_s = zcd_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], zcd_i};
         end
         assign zcd_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zcd_q <= 1'b0;
      else        zcd_q <= zcd_s;
   end

   assign fall_o = zcd_q & ~zcd_s;
endmodule

// File: rtl/pfc_cycle_timer.sv
module pfc_cycle_timer #(
   parameter int unsigned LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic done_o
);
   localparam int unsigned W = pfc_gate_pkg::cnt_width(LIMIT);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr_i)      cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign done_o = (cnt == LIM);
endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl #(
   parameter int unsigned BLANK_CYC   = 20,
   parameter int unsigned START_CYC   = 6667,
   parameter int unsigned MAXON_CYC   = 2500,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic zcd_i,
   input  logic cs_trip_i,
   input  logic cs_sat_i,
   input  logic ovp_i,
   output logic gate_o
);
   import pfc_gate_pkg::*;

   generate
      if (MAXON_CYC <= BLANK_CYC + 1) begin : g_bad_maxon
         $error("MAXON_CYC must exceed BLANK_CYC+1");
      end
      if (START_CYC <= MAXON_CYC) begin : g_bad_start
         $error("START_CYC must exceed MAXON_CYC");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic        zcd_fall;
   logic        blank_done;
   logic        maxon_done;
   logic        start_done;
   logic        turn_on;
   logic        turn_off;
   logic        gate_q;
   stop_cause_e stop;

   always_comb begin
      if (!en_i)         stop = STOP_DIS;
      else if (ovp_i)    stop = STOP_OVP;
      else if (cs_sat_i) stop = STOP_SAT;
      else               stop = STOP_NONE;
   end

   pfc_zcd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .zcd_i(zcd_i), .fall_o(zcd_fall));

   pfc_cycle_timer #(.LIMIT(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr_i(turn_on), .done_o(blank_done));

   pfc_cycle_timer #(.LIMIT(MAXON_CYC - 1)) u_maxon (
      .clk(clk), .rst_n(rst_n), .clr_i(turn_on), .done_o(maxon_done));

   pfc_cycle_timer #(.LIMIT(START_CYC - 1)) u_start (
      .clk(clk), .rst_n(rst_n), .clr_i(turn_on), .done_o(start_done));

   assign turn_on  = !gate_q && (stop == STOP_NONE) && (zcd_fall || start_done);
   assign turn_off = gate_q && ((stop != STOP_NONE) || (blank_done && cs_trip_i) || maxon_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gate_q <= 1'b0;
      else if (turn_on)  gate_q <= 1'b1;
      else if (turn_off) gate_q <= 1'b0;
   end

   assign gate_o = gate_q;
endmodule

// File: rtl/pfc_gate_ctrl_chk.sv
module pfc_gate_ctrl_chk #(
   parameter int unsigned BLANK_CYC = 20,
   parameter int unsigned MAXON_CYC = 2500
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic cs_sat_i,
   input logic ovp_i,
   input logic gate_o
);
   localparam int unsigned W = pfc_gate_pkg::cnt_width(MAXON_CYC);

   logic [W-1:0] on_len;
   logic         inhib;

   assign inhib = !en_i || ovp_i || cs_sat_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    on_len <= '0;
      else if (!gate_o)              on_len <= '0;
      else if (on_len != W'(MAXON_CYC)) on_len <= on_len + 1'b1;
   end

   // R8 R9 R10: any stop condition clears the gate on the next edge
   p_stop_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inhib |=> !gate_o);

   // R2 R3: a rise never happens while a stop condition holds
   p_rise_only_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o) |-> !$past(inhib));

   // R5: inside blanking only a stop condition can end the pulse
   p_blank_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && !inhib && on_len < W'(BLANK_CYC)) |=> gate_o);

   // R7: pulse never exceeds the maximum on-time
   p_maxon_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && on_len >= W'(MAXON_CYC - 1)) |=> !gate_o);
endmodule

bind pfc_gate_ctrl pfc_gate_ctrl_chk #(
   .BLANK_CYC(BLANK_CYC),
   .MAXON_CYC(MAXON_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .cs_sat_i(cs_sat_i),
   .ovp_i(ovp_i), .gate_o(gate_o));

// File: tb/pfc_gate_ctrl_test.sv
module pfc_gate_ctrl_test;
   localparam int BLANK = 8;
   localparam int START = 200;
   localparam int MAXON = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b0;
   logic zcd_i = 1'b1;
   logic cs_trip_i = 1'b0;
   logic cs_sat_i = 1'b0;
   logic ovp_i = 1'b0;
   logic gate_o;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pfc_gate_ctrl #(.BLANK_CYC(BLANK), .START_CYC(START), .MAXON_CYC(MAXON)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .zcd_i(zcd_i),
      .cs_trip_i(cs_trip_i), .cs_sat_i(cs_sat_i), .ovp_i(ovp_i), .gate_o(gate_o));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_level(input logic lvl, output int at);
      do @(negedge clk); while (gate_o !== lvl);
      at = cyc;
   endtask

   task automatic zcd_fall_now();
      zcd_i = 1'b1;
      @(negedge clk);
      zcd_i = 1'b0;
      @(negedge clk);
      zcd_i = 1'b1;
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      check("R1 gate low in reset", gate_o, 0);
      rst_n = 1'b1;
      en_i = 1'b1;
   endtask

   task automatic t_starter();
      int r1, f1, r2;
      cs_trip_i = 1'b1;
      wait_level(1'b1, r1);
      wait_level(1'b0, f1);
      check("R5 high length with trip held", f1 - r1, BLANK + 1);
      wait_level(1'b1, r2);
      check("R3 restart period", r2 - r1, START);
      wait_level(1'b0, f1);
      cs_trip_i = 1'b0;
   endtask

   task automatic t_zcd_maxon();
      int t0, f;
      repeat (3) @(negedge clk);
      zcd_i = 1'b0;
      t0 = cyc;
      @(negedge clk);
      check("R2 turn-on after zcd fall", gate_o, 1);
      check("R2 turn-on latency", cyc - t0, 1);
      zcd_i = 1'b1;
      wait_level(1'b0, f);
      check("R7 maximum on-time", f - t0 - 1, MAXON);
   endtask

   task automatic t_trip_restart();
      int r, r2;
      repeat (3) @(negedge clk);
      zcd_i = 1'b0;
      @(negedge clk);
      zcd_i = 1'b1;
      r = cyc;
      check("R2 turn-on for trip test", gate_o, 1);
      repeat (BLANK + 2) @(negedge clk);
      check("R6 still on before trip", gate_o, 1);
      cs_trip_i = 1'b1;
      @(negedge clk);
      check("R6 off after trip", gate_o, 0);
      cs_trip_i = 1'b0;
      wait_level(1'b1, r2);
      check("R4 restart timed from zcd turn-on", r2 - r, START);
   endtask

   task automatic t_stop(input int which, input string req);
      int highs;
      // gate is high here, inside blanking
      if (which == 0) cs_sat_i = 1'b1;
      else if (which == 1) ovp_i = 1'b1;
      else en_i = 1'b0;
      @(negedge clk);
      check({req, " forced off"}, gate_o, 0);
      highs = 0;
      zcd_fall_now();
      for (int i = 0; i < START + 20; i++) begin
         @(negedge clk);
         if (gate_o) highs++;
      end
      check({req, " held off"}, highs, 0);
      cs_sat_i = 1'b0;
      ovp_i = 1'b0;
      en_i = 1'b1;
      @(negedge clk);
      check({req, " resumes after release"}, gate_o, 1);
   endtask

   initial begin
      int dummy;
      t_reset();
      t_starter();
      t_zcd_maxon();
      t_trip_restart();
      t_stop(0, "R8");
      repeat (2) @(negedge clk);
      wait_level(1'b0, dummy);
      wait_level(1'b1, dummy);
      t_stop(1, "R9");
      wait_level(1'b0, dummy);
      wait_level(1'b1, dummy);
      t_stop(2, "R10");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule